// File: doc/BRIEF.md
# Framebuffer Pixel Fetch Unit

This block streams a stored image out of a byte-wide frame memory and onto a 6-bit colour bus. Each pixel sits in one memory byte. The block keeps a read pointer that walks the frame in raster order. On every pixel strobe that falls inside the visible area, it issues one read, takes the returned byte one system clock later, and shows it as 2-bit red, green and blue levels at the following pixel strobe. The pixel strobe is an internal divide-by-`CLK_DIV` of the system clock. With the default of 4 and a 100 MHz clock, each pixel lasts 40 ns.

A separate timing generator supplies horizontal blank, vertical blank and a frame-start pulse. While either blank is high the block issues no reads, holds its pointer and drives black. The frame-start pulse rewinds the pointer so that the next read is from byte 0. The pointer also wraps to 0 by itself after the last byte of the frame, which is `H_PIX*V_LINES` bytes long (307,200 by default). `CLK_DIV` must be at least 3, so that the byte returns before the next strobe.

Top module: `fbf_fetch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `rd_addr` is 0, `rd_en` is 0 and `red`, `green` and `blue` are all 0.
- R2: Each read strobe `rd_en` lasts one clock. With blanking low, successive strobes are exactly `CLK_DIV` clocks apart. Any two strobes are a multiple of `CLK_DIV` clocks apart.
- R3: Each read presents, on `rd_addr`, the address of the previous read plus one. The address after `H_PIX*V_LINES-1` is 0, and the first read after reset is from address 0.
- R4: A pixel strobe at which `hblank` or `vblank` is high issues no read. `rd_addr` changes only in a cycle in which `rd_en` is high.
- R5: After `frame_start` has been high at a clock edge with no read issued at that edge, the next read is from address 0.
- R6: The byte returned on `rd_data` in the clock after `rd_en` appears at the next read strobe, `CLK_DIV` clocks after its own `rd_en`. It is decoded as red = bits 1:0, green = bits 3:2 and blue = bits 5:4.
- R7: Bits 7:6 of `rd_data` have no effect on the colour outputs.
- R8: If `hblank` or `vblank` is high at a clock edge, all colour outputs are 0 after that edge.
- R9: A pixel strobe that has no fetched byte pending (the first strobe after reset, or the first strobe after a blanked strobe) drives all colour outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| hblank | input | 1 | Horizontal blanking from the timing generator |
| vblank | input | 1 | Vertical blanking from the timing generator |
| frame_start | input | 1 | One-clock pulse that rewinds the read pointer |
| rd_data | input | 8 | Byte returned by frame memory one clock after `rd_en` |
| rd_addr | output | $clog2(H_PIX*V_LINES) | Byte address of the current read |
| rd_en | output | 1 | One-clock read strobe |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
The bench builds the unit with an 8 by 4 frame (32 bytes, a 5-bit address) and keeps the default divide-by-4 strobe. A short active run therefore crosses the last address and checks the wrap to 0, which the full 307,200-byte frame would put out of reach. Blanking stretches of odd lengths move the strobe phase against the blank edges. The memory model flips the two unused top bits during part of the run. A mid-run reset is also applied.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

    // Packed so that {b, g, r} lines up with the low six bits of a stored byte.
    typedef struct packed {
        logic [1:0] b;
        logic [1:0] g;
        logic [1:0] r;
    } rgb_t;

    function automatic rgb_t fbf_decode(input logic [7:0] px_byte);
        rgb_t c;
        c.r = px_byte[1:0];
        c.g = px_byte[3:2];
        c.b = px_byte[5:4];
        return c;
    endfunction

endpackage

// File: rtl/fbf_strobe_gen.sv
module fbf_strobe_gen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic stb
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stb;
    } stb_state_t;

    stb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = (st_q.cnt == CNT_LAST);
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb = st_q.stb;

endmodule

// File: rtl/fbf_addr_gen.sv
module fbf_addr_gen #(
    parameter int FRAME_PIX = 307200,
    parameter int ADDR_W    = $clog2(FRAME_PIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(FRAME_PIX - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] addr;
        logic              en;
    } addr_state_t;

    addr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = 1'b0;
        if (fetch) begin
            st_d.en   = 1'b1;
            st_d.addr = st_q.nxt;
            if (st_q.nxt == ADDR_LAST) begin
                st_d.nxt = '0;
            end else begin
                st_d.nxt = st_q.nxt + 1'b1;
            end
        end
        // Rewind wins over the step of a coincident fetch.
        if (frame_start) begin
            st_d.nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.addr;
    assign rd_en   = st_q.en;

endmodule

// File: rtl/fbf_pixel_path.sv
module fbf_pixel_path
    import fbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  logic       active,
    input  logic       rd_en,
    input  logic [7:0] rd_data,
    output rgb_t       rgb
);
    typedef struct packed {
        logic       lat;
        logic [7:0] px_byte;
        logic       pend;
        rgb_t       rgb;
    } pix_state_t;

    pix_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lat = rd_en;
        if (st_q.lat) begin
            st_d.px_byte = rd_data;
        end
        if (stb) begin
            st_d.rgb  = st_q.pend ? fbf_decode(st_q.px_byte) : '0;
            st_d.pend = active;
        end
        if (!active) begin
            st_d.rgb = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rgb = st_q.rgb;

endmodule

// File: rtl/fbf_fetch_unit.sv
module fbf_fetch_unit
    import fbf_pkg::*;
#(
    parameter int H_PIX   = 640,
    parameter int V_LINES = 480,
    parameter int CLK_DIV = 4,
    localparam int FRAME_PIX = H_PIX * V_LINES,
    localparam int ADDR_W    = $clog2(FRAME_PIX)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              frame_start,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    output logic [1:0]        red,
    output logic [1:0]        green,
    output logic [1:0]        blue
);
    logic stb;
    logic active;
    logic fetch;
    rgb_t rgb;

    assign active = !(hblank || vblank);
    assign fetch  = stb && active;

    fbf_strobe_gen #(
        .CLK_DIV (CLK_DIV)
    ) i_strobe (
        .clk (clk),
        .rst (rst),
        .stb (stb)
    );

    fbf_addr_gen #(
        .FRAME_PIX (FRAME_PIX),
        .ADDR_W    (ADDR_W)
    ) i_addr (
        .clk         (clk),
        .rst         (rst),
        .fetch       (fetch),
        .frame_start (frame_start),
        .rd_addr     (rd_addr),
        .rd_en       (rd_en)
    );

    fbf_pixel_path i_pix (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .active  (active),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .rgb     (rgb)
    );

    assign red   = rgb.r;
    assign green = rgb.g;
    assign blue  = rgb.b;

endmodule

// File: rtl/fbf_fetch_chk.sv
module fbf_fetch_chk #(
    parameter int FRAME_PIX = 307200,
    parameter int CLK_DIV   = 4,
    parameter int ADDR_W    = $clog2(FRAME_PIX)
) (
    input logic              clk,
    input logic              rst,
    input logic              hblank,
    input logic              vblank,
    input logic              frame_start,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_en,
    input logic [1:0]        red,
    input logic [1:0]        green,
    input logic [1:0]        blue
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(FRAME_PIX - 1);

    logic [ADDR_W-1:0] last_q;
    logic              have_q;
    logic              fs_q;
    logic              fsd_q;
    logic [31:0]       gap_q;
    logic [ADDR_W-1:0] step_addr;

    assign step_addr = (last_q == ADDR_LAST) ? '0 : last_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= '0;
            have_q <= 1'b0;
            fs_q   <= 1'b0;
            fsd_q  <= 1'b0;
            gap_q  <= '0;
        end else begin
            fsd_q <= frame_start;
            if (rd_en) begin
                last_q <= rd_addr;
                have_q <= 1'b1;
                gap_q  <= '0;
            end else begin
                gap_q <= gap_q + 1;
            end
            if (frame_start) begin
                fs_q <= 1'b1;
            end else if (rd_en && !fsd_q) begin
                fs_q <= 1'b0;
            end
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!rd_en && rd_addr == '0 && red == 2'b00 && green == 2'b00 && blue == 2'b00));

    // R2
    fetch_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !rd_en);

    // R2
    fetch_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && have_q) |-> (((gap_q + 1) % CLK_DIV) == 0));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && have_q && !fs_q) |-> (rd_addr == step_addr));

    // R5
    addr_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && fs_q && !fsd_q) |-> (rd_addr == '0));

    // R4
    blank_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        (hblank || vblank) |=> !rd_en);

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_addr) |-> rd_en);

    // R8
    blank_black_chk: assert property (@(posedge clk) disable iff (rst)
        (hblank || vblank) |=> (red == 2'b00 && green == 2'b00 && blue == 2'b00));

endmodule

bind fbf_fetch_unit fbf_fetch_chk #(
    .FRAME_PIX (FRAME_PIX),
    .CLK_DIV   (CLK_DIV),
    .ADDR_W    (ADDR_W)
) i_fetch_chk (
    .clk         (clk),
    .rst         (rst),
    .hblank      (hblank),
    .vblank      (vblank),
    .frame_start (frame_start),
    .rd_addr     (rd_addr),
    .rd_en       (rd_en),
    .red         (red),
    .green       (green),
    .blue        (blue)
);

// File: tb/test_fbf_fetch_unit.sv
`timescale 1ns/1ps
module test_fbf_fetch_unit;
    localparam int H_PIX   = 8;
    localparam int V_LINES = 4;
    localparam int DIV     = 4;
    localparam int FRAME   = H_PIX * V_LINES;
    localparam int AW      = $clog2(FRAME);
    localparam int NSEG    = 13;

    // hblank, vblank, frame_start on first cycle, flip top data bits, cycles
    localparam int SEG [NSEG][5] = '{
        '{0, 0, 0, 0, 50},
        '{1, 0, 0, 0, 13},
        '{0, 0, 0, 0, 30},
        '{0, 1, 1, 0, 20},
        '{0, 0, 0, 0, 150},
        '{1, 1, 0, 0, 9},
        '{0, 0, 0, 1, 40},
        '{1, 0, 0, 1, 4},
        '{0, 0, 0, 1, 23},
        '{0, 1, 1, 0, 10},
        '{0, 0, 0, 0, 7},
        '{1, 0, 0, 0, 6},
        '{0, 0, 0, 0, 45}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hblank = 1'b0;
    logic          vblank = 1'b0;
    logic          frame_start = 1'b0;
    logic [7:0]    rd_data = 8'h2A;
    logic [AW-1:0] rd_addr;
    logic          rd_en;
    logic [1:0]    red, green, blue;
    logic          flip = 1'b0;
    logic          done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fbf_fetch_unit #(
        .H_PIX   (H_PIX),
        .V_LINES (V_LINES),
        .CLK_DIV (DIV)
    ) i_fbf_fetch_unit (
        .clk         (clk),
        .rst         (rst),
        .hblank      (hblank),
        .vblank      (vblank),
        .frame_start (frame_start),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .rd_en       (rd_en),
        .red         (red),
        .green       (green),
        .blue        (blue)
    );

    function automatic logic [7:0] mem_byte(input int a);
        return 8'((a * 53 + 200) % 256);
    endfunction

    // Frame memory with one clock of read latency.
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem_byte(int'(rd_addr)) ^ (flip ? 8'hC0 : 8'h00);
        else       rd_data <= 8'h2A;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reactive monitor: expected values follow the requirements.
    bit  have_prev = 0;
    bit  prev_blank = 0;
    int  gap = 0;
    int  prev_addr = 0;
    int  exp_addr = 0;

    always @(negedge clk) begin
        if (rst) begin
            have_prev  = 0;
            prev_blank = 0;
            gap        = 0;
            exp_addr   = 0;
        end else begin
            logic [5:0] col;
            col = {blue, green, red};
            gap++;
            if (prev_blank) begin
                chk(col == 6'd0, "R8 black in blank", int'(col), 0);
                chk(!rd_en, "R4 no read in blank", int'(rd_en), 0);
            end
            if (rd_en) begin
                chk(int'(rd_addr) == exp_addr, "R3 R5 read address", int'(rd_addr), exp_addr);
                if (!have_prev) begin
                    chk(col == 6'd0, "R9 nothing pending", int'(col), 0);
                end else if (gap == DIV) begin
                    chk(col == mem_byte(prev_addr)[5:0], "R6 R7 decoded pixel",
                        int'(col), int'(mem_byte(prev_addr)[5:0]));
                end else begin
                    chk((gap % DIV) == 0, "R2 strobe spacing", gap, DIV);
                    chk(col == 6'd0, "R9 nothing pending", int'(col), 0);
                end
                prev_addr = int'(rd_addr);
                exp_addr  = (int'(rd_addr) + 1) % FRAME;
                have_prev = 1;
                gap       = 0;
            end else if (have_prev) begin
                chk(int'(rd_addr) == prev_addr, "R4 address hold", int'(rd_addr), prev_addr);
            end
            prev_blank = hblank || vblank;
            if (frame_start) exp_addr = 0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(rd_addr == '0, "R1 address", int'(rd_addr), 0);
        chk(!rd_en, "R1 read strobe", int'(rd_en), 0);
        chk({blue, green, red} == 6'd0, "R1 colours", int'({blue, green, red}), 0);
        @(posedge clk); #1;
        rst = 1'b0;

        for (int s = 0; s < NSEG; s++) begin
            for (int c = 0; c < SEG[s][4]; c++) begin
                hblank      = SEG[s][0] != 0;
                vblank      = SEG[s][1] != 0;
                frame_start = (SEG[s][2] != 0) && (c == 0);
                flip        = SEG[s][3] != 0;
                @(posedge clk); #1;
            end
        end
        frame_start = 1'b0;

        // Mid-run reset during active display (R1)
        rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk(rd_addr == '0, "R1 address after mid-run reset", int'(rd_addr), 0);
        chk(!rd_en, "R1 read strobe after mid-run reset", int'(rd_en), 0);
        chk({blue, green, red} == 6'd0, "R1 colours after mid-run reset", int'({blue, green, red}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (60) begin
            @(posedge clk); #1;
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule